// File: doc/BRIEF.md
# Bus Clock Enable Divider Tree

This block turns one free-running system clock into a family of clock-enable pulses for a small microcontroller-style clock tree. Nothing here generates or switches a physical clock. Every derived rate is a one-cycle-wide enable pulse in the system clock domain. A core divider sets the rate of the core and main-bus tick. Two peripheral-bus dividers run from that tick. Beside them sit a fixed divide-by-8 tick for the system timer, one timer tick per peripheral bus and a converter tick taken from the second peripheral bus.

Every bus tick passes through a bank of per-peripheral gates before it reaches a peripheral. The enable bits for these gates arrive on plain register-style inputs. They are captured once per cycle and cleared by reset, so every peripheral starts without a clock until software turns it on. A divider ratio that changes mid-period does not truncate the period already running. The new ratio is loaded only at that divider's terminal count.

Top module: `clk_tick_tree`

## Requirements
- R1: The core tick pulses once every N system-clock cycles. N depends on the 4-bit core select code: 0→1, 1→2, 2→4, 3→8, 4→16, 5→64, 6→128, 7→256, and any code of 8 or above gives 512.
- R2: Each peripheral-bus tick pulses once every M core ticks. M depends on that bus's 3-bit select code: 0→1, 1→2, 2→4, 3→8, and any code of 4 or above gives 16.
- R3: The timer tick of a peripheral bus runs at the bus tick rate when that bus's M is 1. For any other M it runs at twice the bus tick rate, which is once every M/2 core ticks.
- R4: The system-timer tick pulses once every 8 core ticks.
- R5: The converter tick pulses once every D ticks of the second peripheral bus. D is 2×(code+1) for the 2-bit converter select code, so the codes give 2, 4, 6 and 8.
- R6: Each gated peripheral output equals its parent tick (core, bus A or bus B) ANDed with that peripheral's enable bit as captured at the previous clock edge.
- R7: While reset is asserted, every tick and gated output stays low. After release, the captured enable bits read as 0 until the first capture. The core and bus dividers start at ratio 1, the converter divider at 2 and the system-timer divider at 8. Each divider keeps its start ratio until its first terminal count.
- R8: A change to a select input takes effect only at the next terminal count of the period in progress. No tick interval is ever shortened by the change.
- R9: Every derived tick coincides with a pulse of its parent tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| core_div_sel | input | 4 | Core divider select code |
| bus_a_div_sel | input | 3 | Peripheral bus A divider select code |
| bus_b_div_sel | input | 3 | Peripheral bus B divider select code |
| conv_div_sel | input | 2 | Converter divider select code |
| core_en_i | input | CORE_PERIPHS | Enable bits for core-bus peripherals |
| bus_a_en_i | input | BUS_A_PERIPHS | Enable bits for bus A peripherals |
| bus_b_en_i | input | BUS_B_PERIPHS | Enable bits for bus B peripherals |
| core_tick_o | output | 1 | Core and main-bus tick |
| sys_tick_o | output | 1 | System-timer tick |
| bus_a_tick_o | output | 1 | Peripheral bus A tick |
| bus_b_tick_o | output | 1 | Peripheral bus B tick |
| tmr_a_tick_o | output | 1 | Timer tick on bus A |
| tmr_b_tick_o | output | 1 | Timer tick on bus B |
| conv_tick_o | output | 1 | Converter tick |
| core_gated_o | output | CORE_PERIPHS | Gated core ticks, one per peripheral |
| bus_a_gated_o | output | BUS_A_PERIPHS | Gated bus A ticks, one per peripheral |
| bus_b_gated_o | output | BUS_B_PERIPHS | Gated bus B ticks, one per peripheral |

## Verification
The bench builds the block with its default widths: 3 core peripherals, 8 on bus A and 6 on bus B. With these widths every gate bank can be driven with patterns that are all ones, all zeros or random. Random configurations keep the core ratio at 16 or below, so that counting windows stay short enough to cover all bus and converter codes, including the bus codes above 3 that saturate at 16. Directed runs then reach ratio 512 through code 8 and through a code above 8. Further directed runs cover the first ticks after reset and a core ratio change in the middle of a period, where the old interval must complete at full length before the new one starts.

// File: rtl/clk_tree_pkg.sv
package clk_tree_pkg;

  localparam int unsigned RATIO_W    = 10;
  localparam int unsigned CORE_SEL_W = 4;
  localparam int unsigned BUS_SEL_W  = 3;
  localparam int unsigned CONV_SEL_W = 2;
  localparam int unsigned SYS_RATIO  = 8;
  localparam int unsigned CONV_RESET = 2;

  typedef logic [RATIO_W-1:0] ratio_t;

  // Core select code to division ratio; codes past the table saturate.
  function automatic ratio_t core_ratio(input logic [CORE_SEL_W-1:0] code);
    ratio_t r;
    case (code)
      4'd0:    r = ratio_t'(1);
      4'd1:    r = ratio_t'(2);
      4'd2:    r = ratio_t'(4);
      4'd3:    r = ratio_t'(8);
      4'd4:    r = ratio_t'(16);
      4'd5:    r = ratio_t'(64);
      4'd6:    r = ratio_t'(128);
      4'd7:    r = ratio_t'(256);
      default: r = ratio_t'(512);
    endcase
    return r;
  endfunction

  function automatic ratio_t bus_ratio(input logic [BUS_SEL_W-1:0] code);
    ratio_t r;
    case (code)
      3'd0:    r = ratio_t'(1);
      3'd1:    r = ratio_t'(2);
      3'd2:    r = ratio_t'(4);
      3'd3:    r = ratio_t'(8);
      default: r = ratio_t'(16);
    endcase
    return r;
  endfunction

  // Timer ticks run at twice the bus rate unless the bus is undivided.
  function automatic ratio_t tmr_ratio(input ratio_t bus_r);
    return (bus_r == ratio_t'(1)) ? ratio_t'(1) : (bus_r >> 1);
  endfunction

  function automatic ratio_t conv_ratio(input logic [CONV_SEL_W-1:0] code);
    return ratio_t'({code, 1'b0}) + ratio_t'(2);
  endfunction

endpackage

// File: rtl/clk_rst_sync.sv
module clk_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];

endmodule

// File: rtl/tick_divider.sv
module tick_divider
  import clk_tree_pkg::*;
#(
  parameter int unsigned RST_RATIO = 1
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   tick_i,
  input  ratio_t ratio_i,
  output logic   tick_o
);

  localparam ratio_t START_RATIO = ratio_t'(RST_RATIO);

  ratio_t cnt_q, cnt_d;
  ratio_t ratio_q, ratio_d;
  logic   last;

  always_comb begin
    last    = (cnt_q == ratio_q - ratio_t'(1));
    cnt_d   = cnt_q;
    ratio_d = ratio_q;
    if (tick_i) begin
      if (last) begin
        cnt_d   = '0;
        ratio_d = ratio_i;   // new ratio only at terminal count
      end else begin
        cnt_d   = cnt_q + ratio_t'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      ratio_q <= START_RATIO;
    end else if (tick_i) begin
      cnt_q   <= cnt_d;
      ratio_q <= ratio_d;
    end
  end

  assign tick_o = tick_i & last;

endmodule

// File: rtl/tick_gate.sv
module tick_gate #(
  parameter int unsigned N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick_i,
  input  logic [N-1:0] en_i,
  output logic [N-1:0] gated_o
);

  logic [N-1:0] en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= '0;
    else        en_q <= en_i;
  end

  for (genvar i = 0; i < N; i++) begin : g_bit
    assign gated_o[i] = tick_i & en_q[i];
  end

endmodule

// File: rtl/clk_tick_tree.sv
module clk_tick_tree
  import clk_tree_pkg::*;
#(
  parameter int unsigned CORE_PERIPHS  = 3,
  parameter int unsigned BUS_A_PERIPHS = 8,
  parameter int unsigned BUS_B_PERIPHS = 6
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [CORE_SEL_W-1:0]    core_div_sel,
  input  logic [BUS_SEL_W-1:0]     bus_a_div_sel,
  input  logic [BUS_SEL_W-1:0]     bus_b_div_sel,
  input  logic [CONV_SEL_W-1:0]    conv_div_sel,
  input  logic [CORE_PERIPHS-1:0]  core_en_i,
  input  logic [BUS_A_PERIPHS-1:0] bus_a_en_i,
  input  logic [BUS_B_PERIPHS-1:0] bus_b_en_i,
  output logic                     core_tick_o,
  output logic                     sys_tick_o,
  output logic                     bus_a_tick_o,
  output logic                     bus_b_tick_o,
  output logic                     tmr_a_tick_o,
  output logic                     tmr_b_tick_o,
  output logic                     conv_tick_o,
  output logic [CORE_PERIPHS-1:0]  core_gated_o,
  output logic [BUS_A_PERIPHS-1:0] bus_a_gated_o,
  output logic [BUS_B_PERIPHS-1:0] bus_b_gated_o
);

  localparam int unsigned NUM_BUS = 2;

  logic rst_int_n;
  logic core_tick;
  logic sys_tick;
  logic conv_tick;
  logic [NUM_BUS-1:0][BUS_SEL_W-1:0] bus_sel;
  logic [NUM_BUS-1:0] bus_tick;
  logic [NUM_BUS-1:0] tmr_tick;

  clk_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  // Core divider advances every cycle once reset is released.
  tick_divider #(.RST_RATIO(1)) u_core_div (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .tick_i  (rst_int_n),
    .ratio_i (core_ratio(core_div_sel)),
    .tick_o  (core_tick)
  );

  tick_divider #(.RST_RATIO(SYS_RATIO)) u_sys_div (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .tick_i  (core_tick),
    .ratio_i (ratio_t'(SYS_RATIO)),
    .tick_o  (sys_tick)
  );

  assign bus_sel[0] = bus_a_div_sel;
  assign bus_sel[1] = bus_b_div_sel;

  for (genvar g = 0; g < NUM_BUS; g++) begin : g_bus
    tick_divider #(.RST_RATIO(1)) u_bus_div (
      .clk     (clk),
      .rst_n   (rst_int_n),
      .tick_i  (core_tick),
      .ratio_i (bus_ratio(bus_sel[g])),
      .tick_o  (bus_tick[g])
    );
    tick_divider #(.RST_RATIO(1)) u_tmr_div (
      .clk     (clk),
      .rst_n   (rst_int_n),
      .tick_i  (core_tick),
      .ratio_i (tmr_ratio(bus_ratio(bus_sel[g]))),
      .tick_o  (tmr_tick[g])
    );
  end

  tick_divider #(.RST_RATIO(CONV_RESET)) u_conv_div (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .tick_i  (bus_tick[1]),
    .ratio_i (conv_ratio(conv_div_sel)),
    .tick_o  (conv_tick)
  );

  tick_gate #(.N(CORE_PERIPHS)) u_core_gate (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .tick_i  (core_tick),
    .en_i    (core_en_i),
    .gated_o (core_gated_o)
  );

  tick_gate #(.N(BUS_A_PERIPHS)) u_bus_a_gate (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .tick_i  (bus_tick[0]),
    .en_i    (bus_a_en_i),
    .gated_o (bus_a_gated_o)
  );

  tick_gate #(.N(BUS_B_PERIPHS)) u_bus_b_gate (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .tick_i  (bus_tick[1]),
    .en_i    (bus_b_en_i),
    .gated_o (bus_b_gated_o)
  );

  assign core_tick_o  = core_tick;
  assign sys_tick_o   = sys_tick;
  assign bus_a_tick_o = bus_tick[0];
  assign bus_b_tick_o = bus_tick[1];
  assign tmr_a_tick_o = tmr_tick[0];
  assign tmr_b_tick_o = tmr_tick[1];
  assign conv_tick_o  = conv_tick;

endmodule

// File: rtl/clk_tick_tree_chk.sv
module clk_tick_tree_chk
  import clk_tree_pkg::*;
#(
  parameter int unsigned CORE_PERIPHS  = 3,
  parameter int unsigned BUS_A_PERIPHS = 8,
  parameter int unsigned BUS_B_PERIPHS = 6
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic [CORE_SEL_W-1:0]    core_div_sel,
  input logic [BUS_SEL_W-1:0]     bus_a_div_sel,
  input logic [BUS_SEL_W-1:0]     bus_b_div_sel,
  input logic [CONV_SEL_W-1:0]    conv_div_sel,
  input logic [CORE_PERIPHS-1:0]  core_en_i,
  input logic [BUS_A_PERIPHS-1:0] bus_a_en_i,
  input logic [BUS_B_PERIPHS-1:0] bus_b_en_i,
  input logic                     core_tick_o,
  input logic                     sys_tick_o,
  input logic                     bus_a_tick_o,
  input logic                     bus_b_tick_o,
  input logic                     tmr_a_tick_o,
  input logic                     tmr_b_tick_o,
  input logic                     conv_tick_o,
  input logic [CORE_PERIPHS-1:0]  core_gated_o,
  input logic [BUS_A_PERIPHS-1:0] bus_a_gated_o,
  input logic [BUS_B_PERIPHS-1:0] bus_b_gated_o
);

  assert_bus_a_in_core_R9: assert property (@(posedge clk) disable iff (!rst_n)
    bus_a_tick_o |-> core_tick_o);
  assert_bus_b_in_core_R9: assert property (@(posedge clk) disable iff (!rst_n)
    bus_b_tick_o |-> core_tick_o);
  assert_tmr_in_core_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tmr_a_tick_o || tmr_b_tick_o) |-> core_tick_o);
  assert_sys_in_core_R4: assert property (@(posedge clk) disable iff (!rst_n)
    sys_tick_o |-> core_tick_o);
  assert_conv_in_bus_b_R5: assert property (@(posedge clk) disable iff (!rst_n)
    conv_tick_o |-> bus_b_tick_o);
  assert_gate_a_parent_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (|bus_a_gated_o) |-> bus_a_tick_o);
  assert_gate_b_parent_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (|bus_b_gated_o) |-> bus_b_tick_o);
  assert_gate_core_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (core_gated_o & ~$past(core_en_i)) == '0);
  assert_gate_a_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_a_gated_o & ~$past(bus_a_en_i)) == '0);
  assert_quiet_reset_R7: assert property (@(posedge clk)
    !rst_n |-> !(core_tick_o || bus_a_tick_o || bus_b_tick_o || (|bus_b_gated_o)));

endmodule

bind clk_tick_tree clk_tick_tree_chk #(
  .CORE_PERIPHS  (CORE_PERIPHS),
  .BUS_A_PERIPHS (BUS_A_PERIPHS),
  .BUS_B_PERIPHS (BUS_B_PERIPHS)
) u_chk (.*);

// File: tb/clk_tick_tree_test.sv
module clk_tick_tree_test;

  localparam int NC = 3;
  localparam int NA = 8;
  localparam int NB = 6;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [3:0]    core_div_sel;
  logic [2:0]    bus_a_div_sel, bus_b_div_sel;
  logic [1:0]    conv_div_sel;
  logic [NC-1:0] core_en_i;
  logic [NA-1:0] bus_a_en_i;
  logic [NB-1:0] bus_b_en_i;
  logic          core_tick_o, sys_tick_o, bus_a_tick_o, bus_b_tick_o;
  logic          tmr_a_tick_o, tmr_b_tick_o, conv_tick_o;
  logic [NC-1:0] core_gated_o;
  logic [NA-1:0] bus_a_gated_o;
  logic [NB-1:0] bus_b_gated_o;

  clk_tick_tree #(.CORE_PERIPHS(NC), .BUS_A_PERIPHS(NA), .BUS_B_PERIPHS(NB)) uut (
    .clk(clk), .rst_n(rst_n),
    .core_div_sel(core_div_sel), .bus_a_div_sel(bus_a_div_sel),
    .bus_b_div_sel(bus_b_div_sel), .conv_div_sel(conv_div_sel),
    .core_en_i(core_en_i), .bus_a_en_i(bus_a_en_i), .bus_b_en_i(bus_b_en_i),
    .core_tick_o(core_tick_o), .sys_tick_o(sys_tick_o),
    .bus_a_tick_o(bus_a_tick_o), .bus_b_tick_o(bus_b_tick_o),
    .tmr_a_tick_o(tmr_a_tick_o), .tmr_b_tick_o(tmr_b_tick_o),
    .conv_tick_o(conv_tick_o), .core_gated_o(core_gated_o),
    .bus_a_gated_o(bus_a_gated_o), .bus_b_gated_o(bus_b_gated_o)
  );

  always #10 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  int prev_w = 64;
  int c_core, c_sys, c_ba, c_bb, c_ta, c_tb, c_conv;
  int c_gc[NC];
  int c_ga[NA];
  int c_gb[NB];

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int core_n(input int code);
    int t[8] = '{1, 2, 4, 8, 16, 64, 128, 256};
    return (code >= 8) ? 512 : t[code];
  endfunction

  function automatic int bus_m(input int code);
    return (code >= 4) ? 16 : (1 << code);
  endfunction

  function automatic int conv_d(input int code);
    return 2 * (code + 1);
  endfunction

  function automatic int gcd(input int a, input int b);
    int x = a;
    int y = b;
    while (y != 0) begin
      int t = x % y;
      x = y;
      y = t;
    end
    return x;
  endfunction

  function automatic int lcm(input int a, input int b);
    return a / gcd(a, b) * b;
  endfunction

  task automatic count_window(input int w);
    c_core = 0; c_sys = 0; c_ba = 0; c_bb = 0; c_ta = 0; c_tb = 0; c_conv = 0;
    for (int i = 0; i < NC; i++) c_gc[i] = 0;
    for (int i = 0; i < NA; i++) c_ga[i] = 0;
    for (int i = 0; i < NB; i++) c_gb[i] = 0;
    repeat (w) begin
      @(negedge clk);
      c_core += int'(core_tick_o);
      c_sys  += int'(sys_tick_o);
      c_ba   += int'(bus_a_tick_o);
      c_bb   += int'(bus_b_tick_o);
      c_ta   += int'(tmr_a_tick_o);
      c_tb   += int'(tmr_b_tick_o);
      c_conv += int'(conv_tick_o);
      for (int i = 0; i < NC; i++) c_gc[i] += int'(core_gated_o[i]);
      for (int i = 0; i < NA; i++) c_ga[i] += int'(bus_a_gated_o[i]);
      for (int i = 0; i < NB; i++) c_gb[i] += int'(bus_b_gated_o[i]);
    end
  endtask

  task automatic run_cfg(input int cc, input int ac, input int bc, input int dc,
                         input logic [NC-1:0] ec, input logic [NA-1:0] ea,
                         input logic [NB-1:0] eb);
    int n  = core_n(cc);
    int ma = bus_m(ac);
    int mb = bus_m(bc);
    int d  = conv_d(dc);
    int w  = 2 * n * lcm(lcm(ma, mb * d), 8);
    int e_core, e_ba, e_bb, e_ta, e_tb;
    @(negedge clk);
    core_div_sel  = 4'(cc);
    bus_a_div_sel = 3'(ac);
    bus_b_div_sel = 3'(bc);
    conv_div_sel  = 2'(dc);
    core_en_i = ec; bus_a_en_i = ea; bus_b_en_i = eb;
    repeat (prev_w + w) @(negedge clk);
    count_window(w);
    prev_w = w;
    e_core = w / n;
    e_ba   = w / (n * ma);
    e_bb   = w / (n * mb);
    e_ta   = (ma == 1) ? e_ba : 2 * e_ba;
    e_tb   = (mb == 1) ? e_bb : 2 * e_bb;
    chk("R1 core tick count", c_core, e_core);
    chk("R2 bus A tick count", c_ba, e_ba);
    chk("R2 bus B tick count", c_bb, e_bb);
    chk("R3 timer A tick count", c_ta, e_ta);
    chk("R3 timer B tick count", c_tb, e_tb);
    chk("R4 system timer tick count", c_sys, e_core / 8);
    chk("R5 converter tick count", c_conv, e_bb / d);
    for (int i = 0; i < NC; i++) chk("R6 core gated count", c_gc[i], ec[i] ? e_core : 0);
    for (int i = 0; i < NA; i++) chk("R6 bus A gated count", c_ga[i], ea[i] ? e_ba : 0);
    for (int i = 0; i < NB; i++) chk("R6 bus B gated count", c_gb[i], eb[i] ? e_bb : 0);
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int n;
    logic seen;
    void'($urandom(32'd4711));
    rst_n = 1'b0;
    core_div_sel = 4'd2; bus_a_div_sel = 3'd4; bus_b_div_sel = 3'd4; conv_div_sel = 2'd0;
    core_en_i = '1; bus_a_en_i = '1; bus_b_en_i = '1;

    // R7: silence during reset
    repeat (3) @(negedge clk);
    chk("R7 core tick in reset", int'(core_tick_o), 0);
    chk("R7 bus ticks in reset", int'(bus_a_tick_o | bus_b_tick_o), 0);
    chk("R7 gated in reset", int'(|{core_gated_o, bus_a_gated_o, bus_b_gated_o}), 0);

    // R7: start ratios after release
    rst_n = 1'b1;
    seen = 1'b0;
    for (int i = 0; i < 10 && !seen; i++) begin
      @(negedge clk);
      seen = core_tick_o;
    end
    chk("R7 first core tick after release", int'(seen), 1);
    chk("R7 bus A at ratio 1", int'(bus_a_tick_o), 1);
    chk("R7 bus B at ratio 1", int'(bus_b_tick_o), 1);
    chk("R7 timers at ratio 1", int'(tmr_a_tick_o & tmr_b_tick_o), 1);
    chk("R7 system timer starts at 8", int'(sys_tick_o), 0);
    chk("R7 converter starts at 2", int'(conv_tick_o), 0);
    chk("R7 enables cleared", int'(|{core_gated_o, bus_a_gated_o, bus_b_gated_o}), 0);
    @(negedge clk);
    chk("R8 core ratio 4 loaded at terminal count", int'(core_tick_o), 0);

    // Directed: high-performance example, then saturating core codes
    run_cfg(0, 1, 0, 0, '1, '1, '1);
    run_cfg(8, 0, 0, 0, 3'b101, 8'hA5, 6'b010110);
    run_cfg(13, 0, 0, 3, '1, '0, '1);
    run_cfg(0, 7, 5, 2, '0, 8'h3C, '0);

    // Random configurations
    for (int k = 0; k < 6; k++)
      run_cfg(int'($urandom_range(0, 4)), int'($urandom_range(0, 7)),
              int'($urandom_range(0, 7)), int'($urandom_range(0, 3)),
              NC'($urandom), NA'($urandom), NB'($urandom));

    // R8: change mid-period must not shorten the running interval
    run_cfg(4, 0, 0, 0, '0, '0, '0);
    do @(negedge clk); while (!core_tick_o);
    n = 0;
    do begin
      @(negedge clk);
      n++;
      if (n == 5) core_div_sel = 4'd1;
    end while (!core_tick_o);
    chk("R8 interval during change", n, 16);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!core_tick_o);
    chk("R8 interval after change", n, 2);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule